// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block supervises software by demanding a service word, written through a small register port, inside a bounded time window. The window is measured in instruction-cycle ticks. Each service word carries three fields: a fixed 5-bit key, a 2-bit window-size selection and a clock-monitor enable. A service that comes too early, arrives too late or carries a wrong field starts a fixed-length active-low error pulse on `wdog_n_o`. That pulse is meant to drive system reset or an interrupt.

Only the first service after reset configures the block. It picks the window size and decides whether the lost-clock input is watched. After that the configuration is frozen, and every later service must repeat it exactly. The watchdog counter stops while the processor is halted or idle. Leaving HALT restarts the selected window. Leaving IDLE counts as a hardware service. The lost-clock input stays live in both low-power states.

Top module: `wdg_keyed_top`

## Requirements
- R1: While `rst` is high (synchronous, active high), both detectors are held off and `wdog_n_o` stays high, even with `clk_lost_i` high. After reset the read-back value is 0xC1: window code 3 and monitor enabled.
- R2: The service word holds the window code in bits [7:6], the key in bits [5:1] (valid key 5'b01100) and the monitor enable in bit [0]. `rd_data_o` shows the locked window code and enable with bits [5:1] always zero.
- R3: The first service after reset is checked against the key only. It is accepted at any tick count below the window end, including before 2048 ticks. It locks the window code and the monitor enable it carries.
- R4: If no service is made after reset, `wdog_n_o` falls on the 65,536th tick after reset is released.
- R5: A later service is valid when all three fields equal the locked values and at least 2048 ticks have passed since the window last restarted. A valid service restarts the window and leaves `wdog_n_o` high.
- R6: A later service with any mismatching field, or one made before 2048 ticks, starts an error on the next clock.
- R7: Window code c gives a window of 8192·2^c ticks. The error starts on the tick that would reach that count.
- R8: An error holds `wdog_n_o` low for exactly 16 clocks. After that the window restarts at 65,536 ticks and the locked settings are kept.
- R9: After the configuration is locked, service writes never change the read-back value.
- R10: With the monitor enabled, a high `clk_lost_i` starts an error on the next clock, also in HALT or IDLE. With the monitor disabled, `clk_lost_i` has no effect.
- R11: While `halt_i` is high, ticks are not counted and service writes are ignored. On the clock after `halt_i` falls, the window restarts at its selected size, and the 2048-tick lower bound applies again.
- R12: IDLE freezes the block in the same way. On leaving IDLE a hardware service restarts the window at its selected size and locks the configuration if no service had been made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Instruction-cycle tick, counts one window step |
| wr_en_i | input | 1 | Service register write strobe |
| wr_data_i | input | 8 | Service word |
| rd_data_o | output | 8 | Read-back of locked configuration, key bits zero |
| halt_i | input | 1 | Processor in HALT |
| idle_i | input | 1 | Processor in IDLE |
| clk_lost_i | input | 1 | Lost-clock indication from a clock monitor |
| wdog_n_o | output | 1 | Active-low watchdog error |

## Verification
A wrong tick count can only be seen at the window edges. If the counter drifts, a service at tick 2048 or tick 2049 gets the wrong verdict, or the expiry lands one clock off. Both show up on `wdog_n_o` one clock after the deciding edge, so the bench samples exactly there. A corrupt lock or configuration register shows up at once on `rd_data_o`, or as a false error on the next service. A stuck low-power edge detector shows up as a missing restart, which becomes visible one window later.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int SVC_W  = 8;
    localparam int KEY_W  = 5;
    localparam int WSEL_W = 2;

    localparam logic [KEY_W-1:0]  SVC_KEY    = 5'b01100;
    localparam logic [WSEL_W-1:0] WSEL_RESET = 2'b11;

    // bit order is behaviour: [7:6] window, [5:1] key, [0] monitor enable
    typedef struct packed {
        logic [WSEL_W-1:0] wsel;
        logic [KEY_W-1:0]  key;
        logic              mon_en;
    } svc_word_t;

    typedef struct packed {
        logic [WSEL_W-1:0] wsel;
        logic              mon_en;
    } wdg_cfg_t;

    function automatic int unsigned win_span(input int unsigned code, input int unsigned base);
        return base << code;
    endfunction

    function automatic logic [SVC_W-1:0] readback(input wdg_cfg_t c);
        svc_word_t w;
        w.wsel   = c.wsel;
        w.key    = '0;
        w.mon_en = c.mon_en;
        return w;
    endfunction

endpackage

// File: rtl/wdg_win_counter.sv
module wdg_win_counter
    import wdg_pkg::*;
#(
    parameter int BASE_WIN  = 8192,
    parameter int EARLY_MIN = 2048,
    parameter int CNT_W     = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              restart,
    input  logic              use_max,
    input  logic [WSEL_W-1:0] wsel,
    output logic              too_early,
    output logic              expire
);
    localparam int NSEL = 1 << WSEL_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_tab [NSEL];
    logic [CNT_W-1:0] last_cnt;

    genvar g;
    generate
        for (g = 0; g < NSEL; g++) begin : g_lim
            assign last_tab[g] = CNT_W'(win_span(g, BASE_WIN) - 1);
        end
    endgenerate

    assign last_cnt  = use_max ? last_tab[NSEL-1] : last_tab[wsel];
    assign too_early = cnt_q < CNT_W'(EARLY_MIN);
    assign expire    = advance && (cnt_q == last_cnt);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdg_svc_gate.sv
module wdg_svc_gate
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [SVC_W-1:0] wr_word,
    input  logic             too_early,
    input  logic             hw_lock,
    output wdg_cfg_t         cfg,
    output logic             locked,
    output logic             svc_ok,
    output logic             svc_bad
);
    svc_word_t w;
    wdg_cfg_t  cfg_q;
    logic      locked_q;
    logic      key_ok;
    logic      match_all;

    assign w         = svc_word_t'(wr_word);
    assign key_ok    = (w.key == SVC_KEY);
    assign match_all = key_ok && (w.wsel == cfg_q.wsel) && (w.mon_en == cfg_q.mon_en);

    always_comb begin
        svc_ok  = 1'b0;
        svc_bad = 1'b0;
        if (wr_valid) begin
            if (!locked_q) begin
                svc_ok  = key_ok;
                svc_bad = !key_ok;
            end else begin
                svc_ok  = match_all && !too_early;
                svc_bad = !(match_all && !too_early);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q     <= 1'b0;
            cfg_q.wsel   <= WSEL_RESET;
            cfg_q.mon_en <= 1'b1;
        end else if (!locked_q && svc_ok) begin
            locked_q     <= 1'b1;
            cfg_q.wsel   <= w.wsel;
            cfg_q.mon_en <= w.mon_en;
        end else if (hw_lock) begin
            locked_q     <= 1'b1;
        end
    end

    assign cfg    = cfg_q;
    assign locked = locked_q;

endmodule

// File: rtl/wdg_err_pulse.sv
module wdg_err_pulse #(
    parameter int PULSE_LEN = 16,
    parameter int PW        = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic busy,
    output logic ending,
    output logic alarm_n
);
    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end else if (fire) begin
            left_q <= PW'(PULSE_LEN);
        end
    end

    assign busy    = (left_q != '0);
    assign ending  = (left_q == PW'(1));
    assign alarm_n = !busy;

endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top
    import wdg_pkg::*;
#(
    parameter int BASE_WIN  = 8192,
    parameter int EARLY_MIN = 2048,
    parameter int PULSE_LEN = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [SVC_W-1:0] wr_data_i,
    output logic [SVC_W-1:0] rd_data_o,
    input  logic             halt_i,
    input  logic             idle_i,
    input  logic             clk_lost_i,
    output logic             wdog_n_o
);
    localparam int MAX_WIN = BASE_WIN << ((1 << WSEL_W) - 1);
    localparam int CNT_W   = $clog2(MAX_WIN + 1);
    localparam int PW      = $clog2(PULSE_LEN + 1);

    logic     halt_q, idle_q;
    logic     frozen, halt_exit, idle_exit;
    logic     busy, ending;
    logic     advance, wr_valid, mon_trip, fire, restart;
    logic     use_max_q;
    logic     too_early, expire;
    logic     svc_ok, svc_bad, locked;
    logic     cfg_mon;
    wdg_cfg_t cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= 1'b0;
            idle_q <= 1'b0;
        end else begin
            halt_q <= halt_i;
            idle_q <= idle_i;
        end
    end

    assign frozen    = halt_i || idle_i;
    assign halt_exit = halt_q && !halt_i;
    assign idle_exit = idle_q && !idle_i;

    assign advance  = tick_i && !frozen && !busy;
    assign wr_valid = wr_en_i && !frozen && !busy;
    assign cfg_mon  = cfg.mon_en;
    assign mon_trip = cfg_mon && clk_lost_i && !busy;
    assign fire     = svc_bad || (expire && !svc_ok) || mon_trip;
    assign restart  = svc_ok || halt_exit || idle_exit || fire || ending;

    always_ff @(posedge clk) begin
        if (rst) begin
            use_max_q <= 1'b1;
        end else if (fire || ending) begin
            use_max_q <= 1'b1;
        end else if (svc_ok || halt_exit || idle_exit) begin
            use_max_q <= 1'b0;
        end
    end

    wdg_win_counter #(
        .BASE_WIN (BASE_WIN),
        .EARLY_MIN(EARLY_MIN),
        .CNT_W    (CNT_W)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .advance  (advance),
        .restart  (restart),
        .use_max  (use_max_q),
        .wsel     (cfg.wsel),
        .too_early(too_early),
        .expire   (expire)
    );

    wdg_svc_gate u_svc (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_word  (wr_data_i),
        .too_early(too_early),
        .hw_lock  (idle_exit),
        .cfg      (cfg),
        .locked   (locked),
        .svc_ok   (svc_ok),
        .svc_bad  (svc_bad)
    );

    wdg_err_pulse #(
        .PULSE_LEN(PULSE_LEN),
        .PW       (PW)
    ) u_err (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .busy   (busy),
        .ending (ending),
        .alarm_n(wdog_n_o)
    );

    assign rd_data_o = readback(cfg);

endmodule

// File: rtl/wdg_keyed_chk.sv
module wdg_keyed_chk #(
    parameter int PULSE_LEN = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] rd_data_o,
    input logic       halt_i,
    input logic       idle_i,
    input logic       clk_lost_i,
    input logic       wdog_n_o,
    input logic       cfg_mon,
    input logic       svc_ok,
    input logic       locked
);
    int low_run;

    always_ff @(posedge clk) begin
        if (rst || wdog_n_o) low_run <= 0;
        else                 low_run <= low_run + 1;
    end

    assert_pulse_len_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(wdog_n_o) |-> (low_run == PULSE_LEN));

    assert_bad_key_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !halt_i && !idle_i && wdog_n_o && (wr_data_i[5:1] != 5'b01100)) |=> !wdog_n_o);

    assert_valid_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (svc_ok && !(cfg_mon && clk_lost_i)) |=> wdog_n_o);

    assert_clock_trip_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_mon && clk_lost_i && wdog_n_o) |=> !wdog_n_o);

    assert_frozen_only_clock_R11: assert property (@(posedge clk) disable iff (rst)
        ($fell(wdog_n_o) && $past(halt_i || idle_i)) |-> $past(clk_lost_i));

    assert_lock_stable_R9: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(rd_data_o));

endmodule

bind wdg_keyed_top wdg_keyed_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .halt_i    (halt_i),
    .idle_i    (idle_i),
    .clk_lost_i(clk_lost_i),
    .wdog_n_o  (wdog_n_o),
    .cfg_mon   (cfg_mon),
    .svc_ok    (svc_ok),
    .locked    (locked)
);

// File: tb/tb_wdg_keyed_top.sv
`timescale 1ns/100ps
module tb_wdg_keyed_top;
    logic       clk = 1'b0;
    logic       rst, tick, wr_en, halt, idle, clk_lost;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       wdog_n;

    always #2.5 clk = ~clk;

    wdg_keyed_top dut (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .halt_i    (halt),
        .idle_i    (idle),
        .clk_lost_i(clk_lost),
        .wdog_n_o  (wdog_n)
    );

    int  n_run  = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    string      tag_q[$];
    logic       wd_q[$];
    logic [8:0] rd_q[$];
    event       smp_ev;

    task automatic expect_out(input string tag, input logic wd, input bit chk_rd, input logic [7:0] rd);
        tag_q.push_back(tag);
        wd_q.push_back(wd);
        rd_q.push_back({chk_rd, rd});
        ->smp_ev;
        #0.1;
    endtask

    initial begin : monitor
        forever begin
            @(smp_ev);
            while (tag_q.size() > 0) begin : pop_one
                string      t;
                logic       w;
                logic [8:0] r;
                bit         bad;
                t = tag_q.pop_front();
                w = wd_q.pop_front();
                r = rd_q.pop_front();
                bad = 1'b0;
                n_run++;
                if (wdog_n !== w) begin
                    bad = 1'b1;
                    $display("FAIL %s: wdog_n actual %0b expected %0b", t, wdog_n, w);
                end
                if (r[8] && (rd_data !== r[7:0])) begin
                    bad = 1'b1;
                    $display("FAIL %s: rd_data actual %02h expected %02h", t, rd_data, r[7:0]);
                end
                if (bad) n_fail++;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_write(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    // write captured k edges after the current reference edge
    task automatic write_at(input int k, input logic [7:0] d);
        cyc(k - 1);
        drive_write(d);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(3);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual run still busy expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : driver
        rst = 1'b1; tick = 1'b1; wr_en = 1'b0; wr_data = 8'h00;
        halt = 1'b0; idle = 1'b0; clk_lost = 1'b1;
        cyc(2);
        expect_out("R1 reset holds detectors off", 1'b1, 1'b1, 8'hC1);
        clk_lost = 1'b0;
        cyc(1);
        rst = 1'b0;

        // unserviced after reset
        cyc(65535);
        expect_out("R4 no error before 65536 ticks", 1'b1, 1'b0, 8'h00);
        cyc(1);
        expect_out("R4 error at 65536 ticks", 1'b0, 1'b0, 8'h00);
        cyc(15);
        expect_out("R8 pulse still low at clock 16", 1'b0, 1'b0, 8'h00);
        cyc(1);
        expect_out("R8 pulse released after 16 clocks", 1'b1, 1'b0, 8'h00);

        // first service, early, 8k window, monitor on
        write_at(5, 8'h19);
        expect_out("R3 R2 first service early accepted, key reads zero", 1'b1, 1'b1, 8'h01);

        write_at(2048, 8'h19);
        expect_out("R6 service before 2048 ticks", 1'b0, 1'b1, 8'h01);
        cyc(16);
        cyc(9000);
        expect_out("R8 window at maximum after error", 1'b1, 1'b0, 8'h00);
        drive_write(8'h19);
        expect_out("R5 matching service accepted", 1'b1, 1'b0, 8'h00);

        cyc(8191);
        expect_out("R7 no error before 8192 ticks", 1'b1, 1'b0, 8'h00);
        cyc(1);
        expect_out("R7 late error at 8192 ticks", 1'b0, 1'b0, 8'h00);
        cyc(16);

        write_at(2049, 8'h19);
        expect_out("R5 service at 2049th clock accepted", 1'b1, 1'b0, 8'h00);
        write_at(2049, 8'h59);
        expect_out("R6 R9 window field mismatch, config unchanged", 1'b0, 1'b1, 8'h01);
        cyc(16);
        write_at(2049, 8'h18);
        expect_out("R6 R9 monitor field mismatch, config unchanged", 1'b0, 1'b1, 8'h01);
        cyc(16);
        write_at(2049, 8'h29);
        expect_out("R6 key mismatch", 1'b0, 1'b0, 8'h00);
        cyc(16);
        write_at(2049, 8'h19);
        expect_out("R5 service after key error", 1'b1, 1'b0, 8'h00);

        // HALT
        halt = 1'b1;
        cyc(20000);
        expect_out("R11 no expiry while halted", 1'b1, 1'b0, 8'h00);
        drive_write(8'h00);
        expect_out("R11 write ignored while halted", 1'b1, 1'b1, 8'h01);
        clk_lost = 1'b1;
        cyc(1);
        clk_lost = 1'b0;
        expect_out("R10 clock monitor active in halt", 1'b0, 1'b0, 8'h00);
        cyc(16);
        halt = 1'b0;
        cyc(1);
        write_at(2048, 8'h19);
        expect_out("R11 lower bound applies after halt exit", 1'b0, 1'b0, 8'h00);
        cyc(16);
        halt = 1'b1;
        cyc(100);
        halt = 1'b0;
        cyc(1);
        cyc(8191);
        expect_out("R11 selected window reloaded on halt exit", 1'b1, 1'b0, 8'h00);
        cyc(1);
        expect_out("R11 selected window expiry after halt exit", 1'b0, 1'b0, 8'h00);
        cyc(16);

        // monitor disabled
        do_reset();
        write_at(2, 8'h58);
        expect_out("R3 first service picks 16k window, monitor off", 1'b1, 1'b1, 8'h40);
        clk_lost = 1'b1;
        cyc(50);
        clk_lost = 1'b0;
        expect_out("R10 lost clock ignored when monitor disabled", 1'b1, 1'b1, 8'h40);

        // IDLE
        do_reset();
        idle = 1'b1;
        cyc(100);
        idle = 1'b0;
        cyc(1);
        write_at(2049, 8'h19);
        expect_out("R12 idle exit service locked defaults", 1'b0, 1'b1, 8'hC1);
        cyc(16);
        write_at(2049, 8'hD9);
        expect_out("R12 R5 service matching defaults accepted", 1'b1, 1'b0, 8'h00);
        idle = 1'b1;
        cyc(10);
        idle = 1'b0;
        cyc(1);
        write_at(2048, 8'hD9);
        expect_out("R12 lower bound applies after idle exit", 1'b0, 1'b0, 8'h00);
        cyc(16);
        expect_out("R8 released after idle-exit error", 1'b1, 1'b0, 8'h00);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule